// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a master for a three-wire serial EEPROM. It fetches one 16-bit word. The host raises a one-cycle start strobe, presents a word address and says whether the attached device takes a short (6-bit) or a long (8-bit) address. The block then drives chip select, the serial clock and the serial data line, and samples the data returned by the device. When the word has been assembled it appears on the result port, and a one-cycle completion pulse marks it.

Each high and low half of the serial clock lasts `PHASE_CYC` system clocks. The same interval follows every change of chip select or of the outgoing data bit. A transfer runs in a fixed order:

1. Chip select rises and is allowed to settle.
2. One clock pulse is sent that carries no data.
3. The read opcode is sent, followed by the address.
4. The outgoing line is held low while sixteen pulses clock the word back.
5. Chip select falls and is allowed to settle.
6. One trailing clock pulse is sent with chip select low.

Top module: `uwire_rom_reader`

## Requirements
- R1: Out of reset, and whenever no transfer is running, chip select, serial clock, serial data out and the completion pulse are all low.
- R2: A start strobe sampled while idle raises chip select for one phase with the clock low. One clock pulse follows, with data out low. Chip select only changes while the serial clock is low.
- R3: The outgoing bits are the opcode 1, 1, 0 in that order, then the address MSB first. In short mode only the low 6 address bits are sent and the upper address input bits are ignored. In long mode all 8 are sent.
- R4: Each outgoing bit is placed on data out one phase before its clock rises, and it holds through the high and low phases of that pulse.
- R5: Every high phase and every low phase of the serial clock, and every settle interval, lasts exactly `PHASE_CYC` system clocks.
- R6: After the last address bit, data out goes low for one settle phase and stays low for the whole readback.
- R7: The readback has exactly 16 clock pulses. Data in is sampled at the end of each pulse's low phase, and the bits are assembled MSB first. The device's dummy zero falls before the first of these pulses, so no extra pulse is added.
- R8: After the sixteenth pulse, chip select falls and settles for one phase. One more clock pulse is then issued with chip select low before the transfer ends.
- R9: The completion pulse is high for exactly one system clock, in the cycle after the trailing pulse's low phase ends. In that cycle the result port holds the word read.
- R10: A start strobe that arrives while a transfer is running has no effect on the pins, on the result or on the transfer's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to read a word |
| wide_i | input | 1 | 1 selects the 8-bit address device, 0 the 6-bit one |
| addr_i | input | 8 | Word address, sampled with the start strobe |
| cs_o | output | 1 | Chip select to the EEPROM, active high |
| sck_o | output | 1 | Serial clock to the EEPROM, idles low |
| mosi_o | output | 1 | Serial data to the EEPROM |
| miso_i | input | 1 | Serial data from the EEPROM |
| done_o | output | 1 | One-cycle pulse: result valid |
| data_o | output | 16 | Word read from the EEPROM |

## Verification
Chip select rises in the first cycle after the clock edge that samples the start strobe. From then on, every phase lasts `PHASE_CYC` cycles. A short-address read spans 66 phases and a long-address read spans 72. The completion pulse therefore appears exactly 66·`PHASE_CYC` or 72·`PHASE_CYC` cycles after the sampling edge, counting from the first cycle that shows chip select high.

The bench builds, for each request, a queue holding one expected value of chip select, clock, data out and completion per system clock. It pops one entry at every falling edge of the system clock and compares it with the pins. The bench pushes to the queue only after that comparison, so expectation and design stay aligned cycle by cycle.

A behavioural device model on the pins records the opcode and the address it received and drives back a word computed from that address. Both are checked in the completion cycle.

// File: rtl/uwire_rd_pkg.sv
// Package: shared step encoding and the read opcode for the serial
// EEPROM reader. Assumes a 3-bit opcode sent before the address.
package uwire_rd_pkg;

    // Sequencer steps, one phase each except IDLE.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CSON,    // chip select raised, settling
        ST_PREHI,   // leading dummy pulse, high half
        ST_PRELO,   // leading dummy pulse, low half
        ST_SETUP,   // outgoing bit placed, settling
        ST_HI,      // outgoing bit pulse, high half
        ST_LO,      // outgoing bit pulse, low half
        ST_ZERO,    // data out forced low, settling
        ST_RDHI,    // readback pulse, high half
        ST_RDLO,    // readback pulse, low half, sample at end
        ST_CSOFF,   // chip select dropped, settling
        ST_POSTHI,  // trailing pulse, high half
        ST_POSTLO   // trailing pulse, low half
    } step_t;

    localparam logic [2:0] RD_OPCODE = 3'b110;

endpackage

// File: rtl/uwire_phase_timer.sv
// Module: uwire_phase_timer
// Produces a one-cycle tick every PHASE_CYC system clocks while run is high.
// Counting restarts from zero whenever run is low, so the first phase after
// leaving idle is full length. Assumes PHASE_CYC >= 1.
module uwire_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt;

    // Phase counter: wraps on the last cycle of each phase, held at 0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // R5: the counter never leaves its phase window
    p_cnt_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/uwire_shifter.sv
// Module: uwire_shifter
// Holds the outgoing frame (opcode then address, left-aligned) and
// assembles the incoming word. The frame is captured on load; short-mode
// frames drop the upper address bits. Assumes ABITS_LARGE >= ABITS_SMALL.
module uwire_shifter
    import uwire_rd_pkg::*;
#(
    parameter int ABITS_SMALL = 6,
    parameter int ABITS_LARGE = 8,
    parameter int WORD_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   wide,
    input  logic [ABITS_LARGE-1:0] addr,
    input  logic                   shift_tx,
    input  logic                   sample,
    input  logic                   miso,
    output logic                   tx_bit,
    output logic [WORD_W-1:0]      rx_word
);
    localparam int FW  = 3 + ABITS_LARGE;
    localparam int SFW = 3 + ABITS_SMALL;
    localparam int PAD = ABITS_LARGE - ABITS_SMALL;

    logic [FW-1:0]  tx_q;
    logic [FW-1:0]  frame_long;
    logic [FW-1:0]  frame_short;

    assign frame_long  = {RD_OPCODE, addr};
    assign frame_short = FW'({RD_OPCODE, addr[ABITS_SMALL-1:0]}) << PAD;

    // Outgoing frame: captured on load, shifted left after each sent bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= wide ? frame_long : frame_short;
        end else if (shift_tx) begin
            tx_q <= {tx_q[FW-2:0], 1'b0};
        end
    end

    // Incoming word: cleared on load, shifted in MSB first on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (load) begin
            rx_word <= '0;
        end else if (sample) begin
            rx_word <= {rx_word[WORD_W-2:0], miso};
        end
    end

    assign tx_bit = tx_q[FW-1];

    // R3: the first bit of a fresh frame is the opcode's leading one
    p_frame_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tx_bit);

    // R3: short frames never exceed their width (used as a sanity bound)
    initial begin
        assert (SFW <= FW) else $error("short frame wider than long frame");
    end

endmodule

// File: rtl/uwire_seq.sv
// Module: uwire_seq
// Step sequencer for one read: select, dummy pulse, opcode and address bits,
// forced-low readback of WORD_W pulses, deselect, trailing pulse. Each step
// lasts one timer tick. Starts are accepted only in IDLE.
module uwire_seq
    import uwire_rd_pkg::*;
#(
    parameter int ABITS_SMALL = 6,
    parameter int ABITS_LARGE = 8,
    parameter int WORD_W      = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wide,
    input  logic tick,
    output logic busy,
    output logic load,
    output logic shift_tx,
    output logic sample,
    output logic cs,
    output logic sck,
    output logic drive,
    output logic done
);
    localparam int FW  = 3 + ABITS_LARGE;
    localparam int SFW = 3 + ABITS_SMALL;
    localparam int MAXN = (FW > WORD_W) ? FW : WORD_W;
    localparam int NW  = $clog2(MAXN + 1);

    step_t         state;
    step_t         nxt;
    logic [NW-1:0] left;

    assign busy     = (state != ST_IDLE);
    assign load     = (state == ST_IDLE) && start;
    assign shift_tx = (state == ST_LO) && tick;
    assign sample   = (state == ST_RDLO) && tick;

    // Next step: advance on each tick, branch on the remaining bit count.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_CSON;
            ST_CSON:   if (tick) nxt = ST_PREHI;
            ST_PREHI:  if (tick) nxt = ST_PRELO;
            ST_PRELO:  if (tick) nxt = ST_SETUP;
            ST_SETUP:  if (tick) nxt = ST_HI;
            ST_HI:     if (tick) nxt = ST_LO;
            ST_LO:     if (tick) nxt = (left == NW'(1)) ? ST_ZERO : ST_SETUP;
            ST_ZERO:   if (tick) nxt = ST_RDHI;
            ST_RDHI:   if (tick) nxt = ST_RDLO;
            ST_RDLO:   if (tick) nxt = (left == NW'(1)) ? ST_CSOFF : ST_RDHI;
            ST_CSOFF:  if (tick) nxt = ST_POSTHI;
            ST_POSTHI: if (tick) nxt = ST_POSTLO;
            ST_POSTLO: if (tick) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Remaining bits: frame length on start, word length entering readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (load) begin
            left <= wide ? NW'(FW) : NW'(SFW);
        end else if (shift_tx || sample) begin
            left <= (left == NW'(1)) ? NW'(WORD_W) : left - 1'b1;
        end
    end

    // Completion pulse at the end of the trailing pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state == ST_POSTLO) && tick;
    end

    // Pin decode from the step.
    always_comb begin
        cs    = (state != ST_IDLE) && (state != ST_CSOFF) &&
                (state != ST_POSTHI) && (state != ST_POSTLO);
        sck   = (state == ST_PREHI) || (state == ST_HI) ||
                (state == ST_RDHI) || (state == ST_POSTHI);
        drive = (state == ST_SETUP) || (state == ST_HI) || (state == ST_LO);
    end

    // R1: idle means deselected with the clock low
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cs && !sck));

    // R10: a start during a transfer never restarts the sequence
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state != ST_CSON));

    // R7: readback is entered with a full word count
    p_rd_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ZERO) |-> (left == NW'(WORD_W)));

endmodule

// File: rtl/uwire_rom_reader.sv
// Module: uwire_rom_reader (top)
// Reads one word from a three-wire serial EEPROM. Assumes the device
// samples data on the rising clock and presents its dummy zero on the
// last address pulse. PHASE_CYC sets each clock half and settle interval.
module uwire_rom_reader #(
    parameter int PHASE_CYC   = 4,
    parameter int ABITS_SMALL = 6,
    parameter int ABITS_LARGE = 8,
    parameter int WORD_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   wide_i,
    input  logic [ABITS_LARGE-1:0] addr_i,
    output logic                   cs_o,
    output logic                   sck_o,
    output logic                   mosi_o,
    input  logic                   miso_i,
    output logic                   done_o,
    output logic [WORD_W-1:0]      data_o
);
    logic busy, tick, load, shift_tx, sample, drive, tx_bit;

    uwire_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    uwire_seq #(
        .ABITS_SMALL(ABITS_SMALL), .ABITS_LARGE(ABITS_LARGE), .WORD_W(WORD_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_i), .wide(wide_i), .tick(tick),
        .busy(busy), .load(load), .shift_tx(shift_tx), .sample(sample),
        .cs(cs_o), .sck(sck_o), .drive(drive), .done(done_o)
    );

    uwire_shifter #(
        .ABITS_SMALL(ABITS_SMALL), .ABITS_LARGE(ABITS_LARGE), .WORD_W(WORD_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .wide(wide_i), .addr(addr_i),
        .shift_tx(shift_tx), .sample(sample), .miso(miso_i),
        .tx_bit(tx_bit), .rx_word(data_o)
    );

    assign mosi_o = drive & tx_bit;

    // R4: data out never moves on a rising serial clock
    p_mosi_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $stable(mosi_o));

    // R2: chip select edges happen only with the clock low
    p_cs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_o) || $fell(cs_o)) |-> !sck_o);

    // R9: completion is a single-cycle pulse
    p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: data out is low whenever a sample is taken
    p_rd_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !mosi_o);

endmodule

// File: tb/uwire_rom_reader_test.sv
module uwire_rom_reader_test;
    localparam int DLY = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [7:0]  addr_i = 8'h00;
    logic        cs_o, sck_o, mosi_o, done_o;
    logic        miso_i = 1'b0;
    logic [15:0] data_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 0;

    logic [3:0]  q[$];          // {cs, sck, mosi, done} per system clock
    logic [15:0] exp_word;
    logic [7:0]  exp_addr;
    bit          rsp_wide = 0;

    always #5 clk = ~clk;

    uwire_rom_reader #(.PHASE_CYC(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
        .addr_i(addr_i), .cs_o(cs_o), .sck_o(sck_o), .mosi_o(mosi_o),
        .miso_i(miso_i), .done_o(done_o), .data_o(data_o)
    );

    function automatic logic [15:0] rom_word(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    // Behavioural device: records opcode and address, returns rom_word.
    int         rn = 0;
    logic [2:0] rcmd = 3'b000;
    logic [7:0] raddr = 8'h00;
    always @(posedge sck_o or posedge cs_o) begin
        int aw;
        aw = rsp_wide ? 8 : 6;
        if (!sck_o) begin
            rn = 0; rcmd = 3'b000; raddr = 8'h00; miso_i = 1'b0;
        end else if (cs_o) begin
            rn = rn + 1;
            if (rn >= 2 && rn <= 4) rcmd = {rcmd[1:0], mosi_o};
            else if (rn >= 5 && rn <= 4 + aw) raddr = {raddr[6:0], mosi_o};
            if (rn == 4 + aw) miso_i = 1'b0;
            else if (rn >= 5 + aw && rn <= 20 + aw)
                miso_i = rom_word(raddr)[15 - (rn - 5 - aw)];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the reference queue.
    always @(negedge clk) begin
        logic [3:0] e, a;
        cycles++;
        if (rst_n && !finished) begin
            e = (q.size() > 0) ? q.pop_front() : 4'b0000;
            a = {cs_o, sck_o, mosi_o, done_o};
            if (a[3] !== e[3])      check(0, "R2", 32'(a), 32'(e));
            else if (a[2] !== e[2]) check(0, "R5", 32'(a), 32'(e));
            else if (a[1] !== e[1]) check(0, "R3", 32'(a), 32'(e));
            else if (a[0] !== e[0]) check(0, "R9", 32'(a), 32'(e));
            else                    check(1, "R1", 32'(a), 32'(e));
            if (e[0]) begin
                check(data_o === exp_word, "R7", 32'(data_o), 32'(exp_word));
                check(rcmd === 3'b110, "R3", 32'(rcmd), 32'h6);
                check(raddr === exp_addr, "R3", 32'(raddr), 32'(exp_addr));
            end
        end
        if (cycles > 100000 && !finished) begin
            finished = 1;
            check(0, "watchdog", 32'(cycles), 32'd100000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic push_phase(input bit c, input bit s, input bit m);
        for (int i = 0; i < DLY; i++) q.push_back({c, s, m, 1'b0});
    endtask

    // Builds the expected pin trace of one read (R2..R9).
    task automatic build(input bit wide, input logic [7:0] a);
        logic [10:0] fr;
        int n;
        n  = wide ? 11 : 9;
        fr = wide ? {3'b110, a} : {3'b110, a[5:0], 2'b00};
        push_phase(1, 0, 0);                       // R2 select settle
        push_phase(1, 1, 0); push_phase(1, 0, 0);  // R2 dummy pulse
        for (int i = 0; i < n; i++) begin           // R3/R4 bit frames
            push_phase(1, 0, fr[10 - i]);
            push_phase(1, 1, fr[10 - i]);
            push_phase(1, 0, fr[10 - i]);
        end
        push_phase(1, 0, 0);                       // R6 forced low
        for (int i = 0; i < 16; i++) begin          // R7 readback
            push_phase(1, 1, 0); push_phase(1, 0, 0);
        end
        push_phase(0, 0, 0);                       // R8 deselect
        push_phase(0, 1, 0); push_phase(0, 0, 0);  // R8 trailing pulse
        q.push_back(4'b0001);                      // R9 completion
    endtask

    task automatic xfer(input bit wide, input logic [7:0] a, input bit poke);
        @(negedge clk); #1;
        exp_addr = wide ? a : {2'b00, a[5:0]};
        exp_word = rom_word(exp_addr);
        rsp_wide = wide;
        build(wide, a);
        start_i = 1'b1; wide_i = wide; addr_i = a;
        @(negedge clk); #1;
        start_i = 1'b0; addr_i = ~a; wide_i = ~wide;
        if (poke) begin                            // R10 start while busy
            repeat (40) @(negedge clk);
            #1 start_i = 1'b1; addr_i = 8'h11; wide_i = ~wide;
            @(negedge clk); #1 start_i = 1'b0;
            repeat (60) @(negedge clk);
            #1 start_i = 1'b1;
            @(negedge clk); #1 start_i = 1'b0;
        end
        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: pins quiet in reset
        check({cs_o, sck_o, mosi_o, done_o} === 4'b0000, "R1",
              32'({cs_o, sck_o, mosi_o, done_o}), 32'h0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        xfer(1'b0, 8'h00, 1'b0);   // short, zero address
        xfer(1'b0, 8'hFF, 1'b0);   // short, upper bits ignored (R3)
        xfer(1'b1, 8'hA5, 1'b0);   // long, alternating
        xfer(1'b1, 8'hFF, 1'b0);   // long, max
        xfer(1'b1, 8'h00, 1'b1);   // long, with ignored starts (R10)
        xfer(1'b0, 8'h2A, 1'b1);   // short, with ignored starts (R10)
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule